// File: doc/BRIEF.md
# Residue Multiply/Divide Checker

This block watches a 32-bit integer multiplier and divider and flags results that cannot be right. It does not recompute the full result. Every operand and result is reduced modulo 31. 31 is a Mersenne number, so the whole comparison runs on 5-bit residues. A product is accepted when the residues of the two operands multiply to the residue of the product. A division is accepted when divisor times quotient equals dividend minus remainder, modulo 31.

Multiply and divide share one residue datapath. A mode input selects what feeds the small modular multiplier. In divide mode the remainder residue is negated and added to the dividend residue, so the subtraction reuses the modular adder.

The unit under check presents its operands and results together with a valid strobe. The error flag is registered and appears in the cycle after the strobe. Errors whose residue is a multiple of 31 alias and are not seen. The multiply check covers only the low 32 product bits, so it is meaningful only when the true product fits in 32 bits.

Top module: `resmd_checker`

## Requirements
- R1: While reset is applied, and in the first cycle after reset is released, `err_o` is 0.
- R2: `err_o` is 1 only in the cycle directly after a clock edge at which `valid_i` was 1. With `valid_i` at 0, any operand or result values leave `err_o` at 0.
- R3: With `mode_i` = 0 (multiply), a product equal to the exact product of `opa_i` and `opb_i`, where that product fits in 32 bits, gives `err_o` = 0 in the next cycle.
- R4: In multiply mode, a product whose residue mod 31 differs from the residue of the exact product gives `err_o` = 1 in the next cycle. An example is the correct product plus 1.
- R5: With `mode_i` = 1 (divide) and a nonzero divisor, a quotient and remainder that satisfy dividend = divisor·quotient + remainder give `err_o` = 0 in the next cycle.
- R6: In divide mode with a nonzero divisor, a quotient off by one, or a remainder off by one, gives `err_o` = 1 in the next cycle whenever the divisor is not a multiple of 31.
- R7: In divide mode with `opb_i` = 0, no error is raised, whatever the quotient and remainder are.
- R8: Residues are taken mod 31, and a value congruent to 31 counts as 0. A product wrong by exactly 31 is therefore not flagged. Operands at the top of the range are reduced correctly, for example 0xFFFFFFFF ≡ 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| valid_i | input | 1 | Operands and results below are to be checked this cycle |
| mode_i | input | 1 | 0 = multiply check, 1 = divide check |
| opa_i | input | 32 | Multiplicand, or dividend |
| opb_i | input | 32 | Multiplier, or divisor |
| res_main_i | input | 32 | Low product word, or quotient |
| res_rem_i | input | 32 | Remainder (divide mode only) |
| err_o | output | 1 | Registered mismatch flag for the previous valid cycle |

## Verification
Each check has a latency of exactly one cycle. Inputs are applied at a falling edge. They are captured at the next rising edge, and `err_o` is sampled at the following falling edge, with no register in between. The bench gives every stimulus its own cycle. A flag is therefore always attributed to the operation presented just before it, and the cycle that follows shows whether an error clears again. The sweeps cover small operand grids in both modes, divide-by-zero, aliasing by 31 and full-range values. The bench computes its expected flags from integer arithmetic on those operands.

// File: rtl/resmd_pkg.sv
// Shared definitions for the residue multiply/divide checker.
// Assumes a Mersenne modulus of the form 2**RES_W - 1.
package resmd_pkg;
    typedef enum logic {
        OP_MUL = 1'b0,
        OP_DIV = 1'b1
    } resmd_op_e;

    localparam int RESMD_RES_W = 5;
endpackage

// File: rtl/resmd_fold.sv
// Reduces an IN_W-bit unsigned value modulo 2**RES_W - 1.
// Method: add the value's RES_W-bit chunks, then repeatedly add the
// high part back onto the low part (end-around carry). An all-ones
// residue is the same as zero and is reported as zero.
// Assumes RES_W >= 2. Purely combinational.
module resmd_fold #(
    parameter int IN_W  = 32,
    parameter int RES_W = 5
) (
    input  logic [IN_W-1:0]  val_i,
    output logic [RES_W-1:0] res_o
);
    localparam int NCHUNK = (IN_W + RES_W - 1) / RES_W;
    localparam int PAD_W  = NCHUNK * RES_W;
    localparam int SUM_W  = RES_W + $clog2(NCHUNK + 1) + 1;

    logic [PAD_W-1:0] padded;
    logic [SUM_W-1:0] part [NCHUNK+1];
    logic [SUM_W-1:0] acc;

    assign padded  = PAD_W'(val_i);
    assign part[0] = '0;

    // Chain of chunk adders, one per RES_W-bit slice.
    for (genvar g = 0; g < NCHUNK; g++) begin : g_chunk
        assign part[g+1] = part[g] + SUM_W'(padded[g*RES_W +: RES_W]);
    end

    // End-around folding until the sum fits RES_W bits, then 31 -> 0.
    always_comb begin
        acc = part[NCHUNK];
        for (int i = 0; i < SUM_W; i++) begin
            acc = SUM_W'(acc[RES_W-1:0]) + (acc >> RES_W);
        end
        res_o = (acc[RES_W-1:0] == {RES_W{1'b1}}) ? '0 : acc[RES_W-1:0];
    end
endmodule

// File: rtl/resmd_mulmod.sv
// Modular multiply of two residues modulo 2**RES_W - 1.
// Assumes both inputs are already reduced (never all ones).
module resmd_mulmod #(
    parameter int RES_W = 5
) (
    input  logic [RES_W-1:0] a_i,
    input  logic [RES_W-1:0] b_i,
    output logic [RES_W-1:0] p_o
);
    localparam int PW = 2 * RES_W;

    logic [PW-1:0] prod;

    // Small full-width product of the two residues.
    assign prod = PW'(a_i) * PW'(b_i);

    resmd_fold #(.IN_W(PW), .RES_W(RES_W)) u_fold (
        .val_i (prod),
        .res_o (p_o)
    );
endmodule

// File: rtl/resmd_checker.sv
// Residue checker for a DATA_W-bit multiplier/divider.
// Multiply mode: (A mod M)(B mod M) mod M must equal P mod M.
// Divide mode:   (B mod M)(Q mod M) mod M must equal (A - R) mod M.
// M = 2**RES_W - 1. The flag is registered one cycle after valid_i.
// Assumes that a product to be checked fits in DATA_W bits. A zero
// divisor is skipped.
module resmd_checker
    import resmd_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int RES_W  = RESMD_RES_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic              mode_i,
    input  logic [DATA_W-1:0] opa_i,
    input  logic [DATA_W-1:0] opb_i,
    input  logic [DATA_W-1:0] res_main_i,
    input  logic [DATA_W-1:0] res_rem_i,
    output logic              err_o
);
    localparam int          NIN  = 4;
    localparam int          WIDE = 2 * DATA_W;
    localparam logic [RES_W-1:0] MODV = {RES_W{1'b1}};

    resmd_op_e        op;
    logic [DATA_W-1:0] fold_in [NIN];
    logic [RES_W-1:0]  rsd     [NIN];
    logic [RES_W-1:0]  mul_x, lhs, neg_rem, diff, rhs;
    logic [RES_W:0]    add_sum;
    logic              mismatch, skip;

    assign op = resmd_op_e'(mode_i);

    // Gather the four values to be reduced: A, B, main result, remainder.
    assign fold_in[0] = opa_i;
    assign fold_in[1] = opb_i;
    assign fold_in[2] = res_main_i;
    assign fold_in[3] = res_rem_i;

    for (genvar g = 0; g < NIN; g++) begin : g_red
        resmd_fold #(.IN_W(DATA_W), .RES_W(RES_W)) u_red (
            .val_i (fold_in[g]),
            .res_o (rsd[g])
        );
    end

    // Input mux of the shared multiplier: A*B, or Q*B for divide.
    assign mul_x = (op == OP_DIV) ? rsd[2] : rsd[0];

    resmd_mulmod #(.RES_W(RES_W)) u_mul (
        .a_i (mul_x),
        .b_i (rsd[1]),
        .p_o (lhs)
    );

    // Mod-M negation of the remainder residue, then a modular add.
    assign neg_rem = (rsd[3] == '0) ? '0 : (MODV - rsd[3]);
    assign add_sum = {1'b0, rsd[0]} + {1'b0, neg_rem};

    resmd_fold #(.IN_W(RES_W+1), .RES_W(RES_W)) u_sub (
        .val_i (add_sum),
        .res_o (diff)
    );

    // Select the right-hand side and compare.
    assign rhs      = (op == OP_DIV) ? diff : rsd[2];
    assign mismatch = (lhs != rhs);
    assign skip     = (op == OP_DIV) && (opb_i == '0);

    // Registered error flag, cleared by synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) err_o <= 1'b0;
        else        err_o <= valid_i && !skip && mismatch;
    end

    // R8
    residue_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsd[0] != MODV) && (rsd[1] != MODV) && (lhs != MODV) && (diff != MODV));

    // R2
    err_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> $past(valid_i));

    // R7
    div_zero_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && mode_i && opb_i == '0) |=> !err_o);

    // R3
    mul_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !mode_i && WIDE'(res_main_i) == WIDE'(opa_i) * WIDE'(opb_i))
        |=> !err_o);

    // R5
    div_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && mode_i && opb_i != '0 &&
         WIDE'(opb_i) * WIDE'(res_main_i) + WIDE'(res_rem_i) == WIDE'(opa_i))
        |=> !err_o);
endmodule

// File: tb/resmd_checker_bench.sv
module resmd_checker_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_i = 1'b0;
    logic        mode_i = 1'b0;
    logic [31:0] opa_i = '0, opb_i = '0, res_main_i = '0, res_rem_i = '0;
    logic        err_o;
    int          n_cmp = 0, n_bad = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    resmd_checker u_resmd_checker (
        .clk, .rst_n, .valid_i, .mode_i, .opa_i, .opb_i,
        .res_main_i, .res_rem_i, .err_o
    );

    task automatic check(input logic exp, input string req);
        n_cmp++;
        if (err_o !== exp) begin
            n_bad++;
            $display("FAIL %s: err_o=%0b expected=%0b (mode=%0b a=%0d b=%0d r=%0d rem=%0d)",
                     req, err_o, exp, mode_i, opa_i, opb_i, res_main_i, res_rem_i);
        end
    endtask

    // Apply one operation at a falling edge; sample the flag one cycle later.
    task automatic op(input logic v, input logic m, input logic [31:0] a,
                      input logic [31:0] b, input logic [31:0] r,
                      input logic [31:0] q, input logic exp, input string req);
        @(negedge clk);
        valid_i = v; mode_i = m; opa_i = a; opb_i = b;
        res_main_i = r; res_rem_i = q;
        @(negedge clk);
        check(exp, req);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(1'b0, "R1");
        rst_n = 1'b1;
        @(negedge clk);
        check(1'b0, "R1");

        // R2: garbage with valid low is ignored
        op(1'b0, 1'b0, 32'd7, 32'd9, 32'd5, 32'd0, 1'b0, "R2");
        op(1'b0, 1'b1, 32'd100, 32'd7, 32'd3, 32'd3, 1'b0, "R2");

        // R3 / R4: multiply sweep
        for (int a = 0; a <= 40; a++) begin
            for (int b = 0; b <= 40; b++) begin
                op(1'b1, 1'b0, 32'(a), 32'(b), 32'(a*b), 32'd0, 1'b0, "R3");
                op(1'b1, 1'b0, 32'(a), 32'(b), 32'(a*b+1), 32'd0, 1'b1, "R4");
            end
        end
        // error clears again on the next clean operation (R2)
        op(1'b1, 1'b0, 32'd3, 32'd4, 32'd13, 32'd0, 1'b1, "R4");
        op(1'b0, 1'b0, 32'd3, 32'd4, 32'd13, 32'd0, 1'b0, "R2");

        // R5 / R6: divide sweep
        for (int a = 0; a <= 200; a++) begin
            for (int b = 1; b <= 20; b++) begin
                op(1'b1, 1'b1, 32'(a), 32'(b), 32'(a/b), 32'(a%b), 1'b0, "R5");
                op(1'b1, 1'b1, 32'(a), 32'(b), 32'(a/b+1), 32'(a%b), 1'b1, "R6");
                op(1'b1, 1'b1, 32'(a), 32'(b), 32'(a/b), 32'(a%b+1), 1'b1, "R6");
            end
        end

        // R7: zero divisor is skipped
        op(1'b1, 1'b1, 32'd55, 32'd0, 32'd9, 32'd4, 1'b0, "R7");
        op(1'b1, 1'b1, 32'hFFFFFFFF, 32'd0, 32'd1, 32'd0, 1'b0, "R7");

        // R8: aliasing by 31 and full-range residues
        op(1'b1, 1'b0, 32'd6, 32'd7, 32'd42 + 32'd31, 32'd0, 1'b0, "R8");
        op(1'b1, 1'b0, 32'h0000FFFF, 32'h00010001, 32'hFFFFFFFF, 32'd0, 1'b0, "R8");
        op(1'b1, 1'b0, 32'hFFFFFFFF, 32'd1, 32'hFFFFFFFF, 32'd0, 1'b0, "R8");
        op(1'b1, 1'b0, 32'hFFFFFFFF, 32'd1, 32'd3, 32'd0, 1'b0, "R8");
        op(1'b1, 1'b0, 32'hFFFFFFFF, 32'd1, 32'd4, 32'd0, 1'b1, "R8");
        op(1'b1, 1'b1, 32'hFFFFFFFF, 32'd65536, 32'd65535, 32'd65535, 1'b0, "R8");
        op(1'b1, 1'b0, 32'd31, 32'd62, 32'd0, 32'd0, 1'b0, "R8");

        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule